// File: doc/BRIEF.md
# Chip-Select External Memory Bus Controller

This block connects an on-chip request/response port to a slow asynchronous parallel bus. The bus has six active-low chip selects, nine address lines, a 16-bit data path, and active-low read (OE) and write (WE) strobes. The data path is split into an output, an input and an output enable, so the pad ring can build the tristate. Each accepted request is decoded against six address windows. The windows differ in size and are not in chip-select order. The decode gives the chip-select index, and the low nine address bits go out as the external address. The block then runs one bus access. That access is timed by the settings that a small register bank holds for the selected chip select.

The sequencer has five states. **IDLE** accepts a request. **RECOVER** is a turnaround gap with the bus fully released. **LATENCY** holds the chip select low with both strobes high, to cover first-access latency. **STROBE** drives OE or WE low for the wait count. **HOLD** keeps the chip select low and the write data driven after WE rises.

The transitions are as follows. IDLE goes to RECOVER when turnaround is owed. Otherwise IDLE goes to LATENCY when latency is owed, and to STROBE when neither is owed. RECOVER goes to LATENCY or STROBE. LATENCY goes to STROBE. STROBE goes to IDLE after a read and to HOLD after a write. HOLD goes to IDLE. An address that falls in no window never leaves IDLE and is answered with an error. All bus outputs come from flops.

Top module: `xbus_ctrl`

## Requirements
- R1: Address ranges map to chip selects as follows:
  - index 0: 0x1a800000..0x1affffff
  - index 1: 0x1b000000..0x1b7fffff
  - index 2: 0x1b800000..0x1bffffff
  - index 5: 0x1c000000..0x1c7fffff
  - index 4: 0x1c800000..0x1cffffff
  - index 3: 0x1d000000..0x24ffffff
  - During an access, only `ebus_cs_n[index]` goes low.
- R2: A request outside every window gets `resp_valid` and `resp_err` high in the cycle right after acceptance. No chip select or strobe is asserted for it, and it does not change the history used by R5 and R6.
- R3: The strobe phase lasts N+1 cycles, where N is the selected read-wait or write-wait value. During it `ebus_oe_n` is low for a read, or `ebus_we_n` is low for a write, and the chip select is low.
- R4: After every write strobe, the chip select stays low for H+1 more cycles with WE high and the data still driven, where H is the write-hold value.
- R5: Turnaround applies only when the previous bus access was a read, and the new access either targets another chip select or is a write to the same one. It inserts max(R,1) cycles with every chip select high, where R is the recovery value of the chip select that was read. A read after a read on the same chip select, or any access after a write, gets no gap.
- R6: On the first access after reset, and whenever the chip select or address bits [31:4] differ from the previous bus access, the chip select is held low with both strobes high for D cycles before the strobe. D is the read-delta or write-delta value (0..255), and D=0 adds nothing.
- R7: `ebus_doe` is high only during the strobe and hold cycles of a write. It is never high during turnaround or latency, and never together with a low OE.
- R8: The timing settings are captured when the request is accepted. A bank write made during an access changes only later accesses.
- R9: `ebus_addr` carries request address bits [8:0], and `ebus_dout` carries the write data while WE is low. For a read, `resp_rdata` returns `ebus_din` as sampled on the last strobe cycle, and `resp_valid` goes high one cycle after the last strobe or hold cycle.
- R10: After reset, all chip selects, OE and WE are high, `ebus_doe` and `resp_valid` are low, and `req_ready` is high. `req_ready` is high only in IDLE, and the bus is quiet whenever it is high.
- R11: A bank write loads `cfg_wdata` into chip select `cfg_sel` on the clock edge where `cfg_we` is high. The fields are:
  - bits [3:0]: read wait
  - bits [7:4]: write wait
  - bits [11:8]: write hold
  - bits [15:12]: recovery
  - bits [23:16]: read delta
  - bits [31:24]: write delta
  - After reset every field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted this cycle if valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion was an out-of-window error |
| resp_rdata | output | 16 | Read data |
| cfg_we | input | 1 | Timing bank write strobe |
| cfg_sel | input | 3 | Chip select whose settings are written |
| cfg_wdata | input | 32 | Packed timing settings (R11) |
| ebus_cs_n | output | 6 | Active-low chip selects |
| ebus_addr | output | 9 | External address |
| ebus_dout | output | 16 | Data driven to the bus |
| ebus_din | input | 16 | Data read from the bus |
| ebus_doe | output | 1 | Data output enable |
| ebus_oe_n | output | 1 | Active-low read strobe |
| ebus_we_n | output | 1 | Active-low write strobe |

## Verification
Two functions can meet in one cycle. The first is a bank write to the chip select that is being served. The second is the sequencer counting down that chip select's strobe phase.

The bench provokes this by issuing a long read on index 4 and writing new wait settings for index 4 three cycles into that read. It then checks that the read keeps its original strobe length, and that the following access to the same chip select uses the new length. Turnaround and first-access latency also stack in a single access: a write to index 3 after a read of index 3 lands on a new page. The bench checks that the gap and the latency appear one after the other, with the data enable low through both.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int NUM_CS = 6;
    localparam int CS_W   = $clog2(NUM_CS);

    // Packed per-chip-select timing word; first member is the MSB end.
    typedef struct packed {
        logic [7:0] wr_delta;
        logic [7:0] rd_delta;
        logic [3:0] recov;
        logic [3:0] wr_hold;
        logic [3:0] wr_wait;
        logic [3:0] rd_wait;
    } tcfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOVER,
        ST_LATENCY,
        ST_STROBE,
        ST_HOLD
    } seq_state_e;

    // First byte address of each chip-select window.
    function automatic logic [31:0] win_first(input int idx);
        unique case (idx)
            0:       return 32'h1a80_0000;
            1:       return 32'h1b00_0000;
            2:       return 32'h1b80_0000;
            3:       return 32'h1d00_0000;
            4:       return 32'h1c80_0000;
            default: return 32'h1c00_0000;
        endcase
    endfunction

    // Last byte address of each chip-select window.
    function automatic logic [31:0] win_last(input int idx);
        unique case (idx)
            0:       return 32'h1aff_ffff;
            1:       return 32'h1b7f_ffff;
            2:       return 32'h1bff_ffff;
            3:       return 32'h24ff_ffff;
            4:       return 32'h1cff_ffff;
            default: return 32'h1c7f_ffff;
        endcase
    endfunction

endpackage

// File: rtl/xbus_window_dec.sv
module xbus_window_dec
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CS_W-1:0]   hit_cs
);

    logic [NUM_CS-1:0] in_win;

    // One range comparator per window.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(win_first(g));
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(win_last(g));
        assign in_win[g] = (addr >= LO) && (addr <= HI);
    end

    always_comb begin
        hit_cs = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (in_win[i]) begin
                hit_cs = CS_W'(i);
            end
        end
    end

    assign hit = |in_win;

endmodule

// File: rtl/xbus_timing_bank.sv
module xbus_timing_bank
    import xbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CS_W-1:0] wr_sel,
    input  logic [31:0]     wr_word,
    input  logic [CS_W-1:0] rd_sel,
    output tcfg_t           rd_cfg
);

    tcfg_t bank_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && (wr_sel == CS_W'(g))) begin
                bank_q[g] <= tcfg_t'(wr_word);
            end
        end
    end

    always_comb begin
        rd_cfg = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rd_sel == CS_W'(i)) begin
                rd_cfg = bank_q[i];
            end
        end
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXT_AW = 9,
    parameter int PAGE_W = 28,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [EXT_AW-1:0] req_low,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hit,
    input  logic [CS_W-1:0]   hit_cs,
    input  tcfg_t             cfg,
    input  logic [DATA_W-1:0] ebus_din,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [NUM_CS-1:0] cs_n,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic              oe_n,
    output logic              we_n
);

    seq_state_e        state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;

    // Access context captured at acceptance.
    logic              cur_wr;
    logic [CS_W-1:0]   cur_cs;
    logic [3:0]        cur_wait;
    logic [3:0]        cur_hold;
    logic [CNT_W-1:0]  lat_len;

    // History of the previous bus access.
    logic              have_prev;
    logic              prev_rd;
    logic [CS_W-1:0]   prev_cs;
    logic [PAGE_W-1:0] prev_page;
    logic [3:0]        prev_rec;

    logic              accept, acc_hit, acc_miss;
    logic              need_rec, first_acc;
    logic [CNT_W-1:0]  lat_new, rec_len;
    logic [3:0]        wait_new;
    logic              sel_wr, drive_cs, fin_read, fin_any;
    logic [CS_W-1:0]   sel_cs;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign acc_hit   = accept && hit;
    assign acc_miss  = accept && !hit;

    assign need_rec  = have_prev && prev_rd && ((hit_cs != prev_cs) || req_write);
    assign first_acc = !have_prev || (hit_cs != prev_cs) || (req_page != prev_page);
    assign lat_new   = first_acc ? (req_write ? cfg.wr_delta : cfg.rd_delta) : '0;
    assign wait_new  = req_write ? cfg.wr_wait : cfg.rd_wait;
    assign rec_len   = (prev_rec == 4'd0) ? CNT_W'(1) : CNT_W'(prev_rec);

    // Next state and counter.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (acc_hit) begin
                    if (need_rec) begin
                        state_nxt = ST_RECOVER;
                        cnt_nxt   = rec_len - CNT_W'(1);
                    end else if (lat_new != '0) begin
                        state_nxt = ST_LATENCY;
                        cnt_nxt   = lat_new - CNT_W'(1);
                    end else begin
                        state_nxt = ST_STROBE;
                        cnt_nxt   = CNT_W'(wait_new);
                    end
                end
            end
            ST_RECOVER: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - CNT_W'(1);
                end else if (lat_len != '0) begin
                    state_nxt = ST_LATENCY;
                    cnt_nxt   = lat_len - CNT_W'(1);
                end else begin
                    state_nxt = ST_STROBE;
                    cnt_nxt   = CNT_W'(cur_wait);
                end
            end
            ST_LATENCY: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - CNT_W'(1);
                end else begin
                    state_nxt = ST_STROBE;
                    cnt_nxt   = CNT_W'(cur_wait);
                end
            end
            ST_STROBE: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - CNT_W'(1);
                end else if (cur_wr) begin
                    state_nxt = ST_HOLD;
                    cnt_nxt   = CNT_W'(cur_hold);
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - CNT_W'(1);
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Access context and history capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_wr    <= 1'b0;
            cur_cs    <= '0;
            cur_wait  <= '0;
            cur_hold  <= '0;
            lat_len   <= '0;
            have_prev <= 1'b0;
            prev_rd   <= 1'b0;
            prev_cs   <= '0;
            prev_page <= '0;
            prev_rec  <= '0;
            ext_addr  <= '0;
            dout      <= '0;
        end else if (acc_hit) begin
            cur_wr    <= req_write;
            cur_cs    <= hit_cs;
            cur_wait  <= wait_new;
            cur_hold  <= cfg.wr_hold;
            lat_len   <= lat_new;
            have_prev <= 1'b1;
            prev_rd   <= !req_write;
            prev_cs   <= hit_cs;
            prev_page <= req_page;
            prev_rec  <= cfg.recov;
            ext_addr  <= req_low;
            if (req_write) begin
                dout <= req_wdata;
            end
        end
    end

    assign sel_wr   = (state == ST_IDLE) ? req_write : cur_wr;
    assign sel_cs   = (state == ST_IDLE) ? hit_cs    : cur_cs;
    assign drive_cs = (state_nxt == ST_LATENCY) || (state_nxt == ST_STROBE) ||
                      (state_nxt == ST_HOLD);
    assign fin_read = (state == ST_STROBE) && (cnt == '0) && !cur_wr;
    assign fin_any  = fin_read || ((state == ST_HOLD) && (cnt == '0));

    // Registered bus strobes and response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n       <= '1;
            oe_n       <= 1'b1;
            we_n       <= 1'b1;
            doe        <= 1'b0;
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            for (int i = 0; i < NUM_CS; i++) begin
                cs_n[i] <= !(drive_cs && (sel_cs == CS_W'(i)));
            end
            oe_n       <= !((state_nxt == ST_STROBE) && !sel_wr);
            we_n       <= !((state_nxt == ST_STROBE) && sel_wr);
            doe        <= sel_wr && ((state_nxt == ST_STROBE) || (state_nxt == ST_HOLD));
            resp_valid <= acc_miss || fin_any;
            resp_err   <= acc_miss;
            if (fin_read) begin
                resp_rdata <= ebus_din;
            end
        end
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int EXT_AW   = 9,
    parameter int PAGE_LSB = 4,
    parameter int CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  resp_valid,
    output logic                  resp_err,
    output logic [DATA_W-1:0]     resp_rdata,
    input  logic                  cfg_we,
    input  logic [CS_W-1:0]       cfg_sel,
    input  logic [31:0]           cfg_wdata,
    output logic [NUM_CS-1:0]     ebus_cs_n,
    output logic [EXT_AW-1:0]     ebus_addr,
    output logic [DATA_W-1:0]     ebus_dout,
    input  logic [DATA_W-1:0]     ebus_din,
    output logic                  ebus_doe,
    output logic                  ebus_oe_n,
    output logic                  ebus_we_n
);

    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    logic            dec_hit;
    logic [CS_W-1:0] dec_cs;
    tcfg_t           sel_cfg;

    xbus_window_dec #(
        .ADDR_W (ADDR_W)
    ) dec_i (
        .addr   (req_addr),
        .hit    (dec_hit),
        .hit_cs (dec_cs)
    );

    xbus_timing_bank bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_word (cfg_wdata),
        .rd_sel  (dec_cs),
        .rd_cfg  (sel_cfg)
    );

    xbus_seq #(
        .DATA_W (DATA_W),
        .EXT_AW (EXT_AW),
        .PAGE_W (PAGE_W),
        .CNT_W  (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_page   (req_addr[ADDR_W-1:PAGE_LSB]),
        .req_low    (req_addr[EXT_AW-1:0]),
        .req_wdata  (req_wdata),
        .hit        (dec_hit),
        .hit_cs     (dec_cs),
        .cfg        (sel_cfg),
        .ebus_din   (ebus_din),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata),
        .cs_n       (ebus_cs_n),
        .ext_addr   (ebus_addr),
        .dout       (ebus_dout),
        .doe        (ebus_doe),
        .oe_n       (ebus_oe_n),
        .we_n       (ebus_we_n)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk
    import xbus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] ebus_cs_n,
    input logic              ebus_oe_n,
    input logic              ebus_we_n,
    input logic              ebus_doe,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_err
);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ebus_cs_n));

    // R3
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ebus_oe_n || !ebus_we_n) |-> !(&ebus_cs_n));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ebus_oe_n && !ebus_we_n));

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ebus_doe |-> (ebus_oe_n && !(&ebus_cs_n)));

    // R4
    hold_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ebus_we_n) |-> (!(&ebus_cs_n) && ebus_doe));

    // R2
    err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> (&ebus_cs_n && ebus_oe_n && ebus_we_n));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&ebus_cs_n && ebus_oe_n && ebus_we_n && !ebus_doe));

endmodule

bind xbus_ctrl xbus_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ebus_cs_n  (ebus_cs_n),
    .ebus_oe_n  (ebus_oe_n),
    .ebus_we_n  (ebus_we_n),
    .ebus_doe   (ebus_doe),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_err   (resp_err)
);

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_err;
    logic [15:0] resp_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  ebus_cs_n;
    logic [8:0]  ebus_addr;
    logic [15:0] ebus_dout;
    logic [15:0] ebus_din = '0;
    logic        ebus_doe;
    logic        ebus_oe_n;
    logic        ebus_we_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ebus_cs_n(ebus_cs_n), .ebus_addr(ebus_addr), .ebus_dout(ebus_dout),
        .ebus_din(ebus_din), .ebus_doe(ebus_doe), .ebus_oe_n(ebus_oe_n),
        .ebus_we_n(ebus_we_n)
    );

    // Reference model of the timing bank (R11 field layout) and access history.
    int m_rw [6], m_ww [6], m_hd [6], m_rc [6], m_rdd [6], m_wrd [6];
    bit          pv;
    bit          prd;
    int          pcs;
    logic [27:0] ppage;
    int          prec;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [15:0] wdata;
        logic [15:0] din;
        logic        err;
        logic [2:0]  cs;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h1a80_0000, 1'b0, 16'h0000, 16'h1234, 1'b0, 3'd0},
        '{32'h1a80_0004, 1'b0, 16'h0000, 16'hbeef, 1'b0, 3'd0},
        '{32'h1a80_0008, 1'b1, 16'ha5a5, 16'h0000, 1'b0, 3'd0},
        '{32'h1aff_ffff, 1'b0, 16'h0000, 16'h0f0f, 1'b0, 3'd0},
        '{32'h1b00_0000, 1'b0, 16'h0000, 16'h7001, 1'b0, 3'd1},
        '{32'h1b7f_fffe, 1'b1, 16'h5a5a, 16'h0000, 1'b0, 3'd1},
        '{32'h1a7f_ffff, 1'b0, 16'h0000, 16'h0000, 1'b1, 3'd0},
        '{32'h1b80_0000, 1'b0, 16'h0000, 16'hc0de, 1'b0, 3'd2},
        '{32'h1bff_fff0, 1'b1, 16'h1357, 16'h0000, 1'b0, 3'd2},
        '{32'h1c00_0000, 1'b0, 16'h0000, 16'h2468, 1'b0, 3'd5},
        '{32'h1c80_0000, 1'b0, 16'h0000, 16'h9999, 1'b0, 3'd4},
        '{32'h1d00_0000, 1'b0, 16'h0000, 16'h4321, 1'b0, 3'd3},
        '{32'h24ff_ffff, 1'b1, 16'hfedc, 16'h0000, 1'b0, 3'd3},
        '{32'h2500_0000, 1'b0, 16'h0000, 16'h0000, 1'b1, 3'd0},
        '{32'h1c7f_ffff, 1'b0, 16'h0000, 16'h6161, 1'b0, 3'd5},
        '{32'h1cff_fffe, 1'b1, 16'h0bad, 16'h0000, 1'b0, 3'd4},
        '{32'h0000_0000, 1'b0, 16'h0000, 16'h0000, 1'b1, 3'd0}
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_cfg(int rw, int ww, int hd, int rc, int rdd, int wrd);
        return {8'(wrd), 8'(rdd), 4'(rc), 4'(hd), 4'(ww), 4'(rw)};
    endfunction

    task automatic set_model(int c, int rw, int ww, int hd, int rc, int rdd, int wrd);
        m_rw[c] = rw; m_ww[c] = ww; m_hd[c] = hd;
        m_rc[c] = rc; m_rdd[c] = rdd; m_wrd[c] = wrd;
    endtask

    task automatic write_cfg(int c, int rw, int ww, int hd, int rc, int rdd, int wrd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(c);
        cfg_wdata = pack_cfg(rw, ww, hd, rc, rdd, wrd);
        @(negedge clk);
        cfg_we = 1'b0;
        set_model(c, rw, ww, hd, rc, rdd, wrd);
    endtask

    // R11: program all six slots
    task automatic program_all();
        write_cfg(0, 1, 2, 0, 0, 3, 0);
        write_cfg(1, 0, 0, 2, 3, 0, 2);
        write_cfg(2, 9, 9, 3, 0, 28, 31);
        write_cfg(3, 2, 1, 1, 5, 1, 1);
        write_cfg(4, 15, 15, 15, 15, 0, 0);
        write_cfg(5, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int c = 0; c < 6; c++) set_model(c, 0, 0, 0, 0, 0, 0);
        pv = 1'b0; prd = 1'b0; pcs = 0; ppage = '0; prec = 0;
        // R10: reset state
        chk(ebus_cs_n == 6'h3f, "R10 cs_n in reset", int'(ebus_cs_n), 63);
        chk(ebus_oe_n && ebus_we_n, "R10 strobes in reset", int'({ebus_oe_n, ebus_we_n}), 3);
        chk(!ebus_doe && !resp_valid, "R10 doe/resp in reset", int'({ebus_doe, resp_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    endtask

    task automatic run_access(input logic [31:0] a, input logic w, input logic [15:0] wd,
                              input logic [15:0] di, input logic e_err, input int e_cs,
                              input bit mid, input logic [31:0] mid_word);
        int rec, lat, strb, hold, e_n;
        bit first;
        int n, pre, cslow, oec, wec, doec, badcs, badad, badd;
        rec = 0; lat = 0; strb = 0; hold = 0;
        if (!e_err) begin
            rec   = (pv && prd && (e_cs != pcs || w)) ? ((prec == 0) ? 1 : prec) : 0;
            first = !pv || (e_cs != pcs) || (a[31:4] != ppage);
            lat   = first ? (w ? m_wrd[e_cs] : m_rdd[e_cs]) : 0;
            strb  = (w ? m_ww[e_cs] : m_rw[e_cs]) + 1;
            hold  = w ? m_hd[e_cs] + 1 : 0;
        end
        e_n = rec + lat + strb + hold + 1;

        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd; ebus_din = di;
        chk(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
        n = 0; pre = 0; cslow = 0; oec = 0; wec = 0; doec = 0;
        badcs = 0; badad = 0; badd = 0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            n++;
            if (mid && n == 3) begin
                cfg_we = 1'b1; cfg_sel = 3'(e_cs); cfg_wdata = mid_word;
            end
            if (mid && n == 4) cfg_we = 1'b0;
            if (ebus_cs_n != 6'h3f) begin
                cslow++;
                if (e_err || ebus_cs_n != ~(6'b1 << e_cs)) badcs++;
            end else if (cslow == 0 && !resp_valid) begin
                pre++;
            end
            if (!ebus_oe_n) begin
                oec++;
                if (ebus_addr != a[8:0]) badad++;
            end
            if (!ebus_we_n) begin
                wec++;
                if (ebus_addr != a[8:0]) badad++;
                if (ebus_dout != wd) badd++;
            end
            if (ebus_doe) begin
                doec++;
                if (ebus_dout != wd) badd++;
            end
            if (resp_valid || n > 700) break;
        end

        chk(resp_err == e_err, e_err ? "R2 error flag" : "R1 hit without error",
            int'(resp_err), int'(e_err));
        chk(n == e_n, "R3 R4 R5 R6 response cycle", n, e_n);
        chk(badcs == 0, "R1 only the decoded chip select", badcs, 0);
        if (e_err) begin
            chk(cslow == 0 && oec == 0 && wec == 0, "R2 no bus activity", cslow + oec + wec, 0);
        end else begin
            chk(pre == rec, "R5 turnaround gap", pre, rec);
            chk(cslow == lat + strb + hold, "R6 R4 chip-select low cycles", cslow, lat + strb + hold);
            chk(oec == (w ? 0 : strb), "R3 read strobe cycles", oec, w ? 0 : strb);
            chk(wec == (w ? strb : 0), "R3 write strobe cycles", wec, w ? strb : 0);
            chk(doec == (w ? strb + hold : 0), "R7 data enable cycles", doec, w ? strb + hold : 0);
            chk(badad == 0 && badd == 0, "R9 address and write data", badad + badd, 0);
            if (!w) chk(resp_rdata == di, "R9 read data", int'(resp_rdata), int'(di));
            prec  = m_rc[e_cs];
            pv    = 1'b1; prd = !w; pcs = e_cs; ppage = a[31:4];
        end
        if (mid) begin
            set_model(e_cs, int'(mid_word[3:0]), int'(mid_word[7:4]), int'(mid_word[11:8]),
                      int'(mid_word[15:12]), int'(mid_word[23:16]), int'(mid_word[31:24]));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        program_all();

        // Table walk: R1 windows and edges, R2 misses, R5 turnaround, R6 pages.
        for (int i = 0; i < NV; i++) begin
            run_access(VECS[i].addr, VECS[i].wr, VECS[i].wdata, VECS[i].din,
                       VECS[i].err, int'(VECS[i].cs), 1'b0, 32'h0);
        end

        // R8: long read on index 4 with a bank change mid-access (waits become 1).
        run_access(32'h1c80_0010, 1'b0, 16'h0, 16'h3c3c, 1'b0, 4, 1'b1,
                   pack_cfg(1, 1, 0, 2, 0, 0));
        run_access(32'h1c80_0014, 1'b0, 16'h0, 16'h4d4d, 1'b0, 4, 1'b0, 32'h0);
        // R5: read then read on the same chip select has no gap.
        run_access(32'h1c80_0018, 1'b0, 16'h0, 16'h5e5e, 1'b0, 4, 1'b0, 32'h0);
        // R5: read then write on the same chip select uses recovery of 2.
        run_access(32'h1c80_001c, 1'b1, 16'h6f6f, 16'h0, 1'b0, 4, 1'b0, 32'h0);

        // R6: the first access after a fresh reset pays latency even on the old page.
        do_reset();
        program_all();
        run_access(32'h1a80_0000, 1'b0, 16'h0, 16'h7777, 1'b0, 0, 1'b0, 32'h0);
        run_access(32'h1a80_000e, 1'b0, 16'h0, 16'h8888, 1'b0, 0, 1'b0, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule